// File: doc/BRIEF.md
# Temperature Limit Alert Controller

This block watches a stream of 12-bit two's-complement temperature results and drives one alert line. Each result comes with a one-cycle strobe. The block compares the result with a programmable upper threshold and a programmable lower threshold. A result counts as a fault only if enough qualifying results arrive in a row. The number needed is set by a 2-bit fault selector. The threshold and mode values arrive as inputs. Register storage and bus decoding sit outside this block.

The block has two modes.

- **Level mode** (`mode_intr` = 0): the alert acts as a thermostat with hysteresis. It rises on high readings and falls once readings drop below the lower threshold.
- **Event mode** (`mode_intr` = 1): the alert latches until software acknowledges it, either by reading any register or by an alert-response acknowledge. After each acknowledge the block swaps the threshold it watches. It watches the upper threshold first, then the lower one, then the upper one again, and so on.

Shutdown and a general reset both clear the alert. A polarity input selects whether the pin is active-high or active-low.

Top module: `temp_alert_ctrl`

## Requirements
- R1: In level mode, with the alert inactive, the alert becomes active once the set number of consecutive results are greater than or equal to `lim_hi`. Equality counts.
- R2: In level mode, with the alert active, the alert becomes inactive once the set number of consecutive results are strictly less than `lim_lo`. A result equal to `lim_lo` does not count.
- R3: `fault_sel` sets the number of consecutive results needed: 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4 and 2'b11 needs 6. A strobed result that does not qualify sets the run count back to zero. Cycles with no strobe leave the count unchanged.
- R4: In event mode, once the set number of consecutive results are at or above `lim_hi`, the alert becomes active. It then stays active whatever the later results are, until `reg_rd` or `ara_ack` is seen. In level mode, `reg_rd` and `ara_ack` have no effect on the alert.
- R5: In event mode, an acknowledge that clears the alert swaps the watched threshold. After an upper-threshold event, only results strictly below `lim_lo` can raise the alert. After that event is acknowledged, only results at or above `lim_hi` can raise it again.
- R6: While `shdn` is high, the alert is inactive and strobed results are ignored. If shutdown clears an event-mode alert, the watched threshold swaps, exactly as it would for an acknowledge.
- R7: A one-cycle `gen_rst` pulse clears the alert and the run count, and sets event mode back to watching `lim_hi`.
- R8: All comparisons are signed and use all 12 bits of the result and the thresholds. For example, 12'h4AF is below 12'h4B0, and 12'hF00 (a negative value) is below any positive threshold.
- R9: When `pol_hi` is 1, the active alert level on `alert_o` is 1. When `pol_hi` is 0, the active level is 0. The polarity applies in the same cycle it changes, and at reset the pin sits at its inactive level.
- R10: In event mode, if an acknowledge and a result strobe arrive in the same cycle while the alert is active, the acknowledge wins. The alert clears, the watched threshold swaps, and that result is dropped.
- R11: A result that completes a run changes `alert_o` after the first rising clock edge at which it is strobed, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | New temperature result strobe |
| sample_temp | input | 12 | Temperature result, two's complement, 1/16 degree per LSB |
| lim_hi | input | 12 | Upper threshold, same format |
| lim_lo | input | 12 | Lower threshold, same format |
| mode_intr | input | 1 | 0 = level mode, 1 = event mode |
| fault_sel | input | 2 | Consecutive-result selector |
| reg_rd | input | 1 | Strobe: any register was read |
| ara_ack | input | 1 | Strobe: alert-response acknowledge succeeded |
| shdn | input | 1 | Shutdown level |
| gen_rst | input | 1 | General reset strobe |
| pol_hi | input | 1 | 1 = active-high alert, 0 = active-low alert |
| alert_o | output | 1 | Alert pin level |

## Verification
In event mode, an acknowledge and a new result can arrive in the same cycle. The bench sets this up by strobing `reg_rd` together with a result above the upper threshold while an upper-threshold alert is pending. The bench then requires the alert to be inactive. It also requires that the next results below the lower threshold raise the alert after exactly the selected run length, which shows the dropped result added nothing to the count. Shutdown arriving in the same cycle as a qualifying result is handled the same way: the bench checks that the result leaves no trace once shutdown is released.

// File: rtl/tac_pkg.sv
package tac_pkg;

  // Run-length selector: how many consecutive qualifying results are needed.
  typedef enum logic [1:0] {
    RUN_ONE  = 2'b00,
    RUN_TWO  = 2'b01,
    RUN_FOUR = 2'b10,
    RUN_SIX  = 2'b11
  } run_sel_e;

  // Threshold that event mode is currently watching.
  typedef enum logic {
    WATCH_HI = 1'b0,
    WATCH_LO = 1'b1
  } watch_e;

  function automatic logic [2:0] run_need(input run_sel_e sel);
    case (sel)
      RUN_ONE:  run_need = 3'd1;
      RUN_TWO:  run_need = 3'd2;
      RUN_FOUR: run_need = 3'd4;
      default:  run_need = 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/tac_rst_sync.sv
// Reset asserts asynchronously and is released synchronously.
module tac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tac_limit_cmp.sv
// Full-width signed comparison against both thresholds.
module tac_limit_cmp #(
  parameter int TEMP_W = 12
) (
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] hi_i,
  input  logic [TEMP_W-1:0] lo_i,
  output logic              ge_hi_o,
  output logic              lt_lo_o
);
  logic signed [TEMP_W-1:0] t_s, h_s, l_s;

  always_comb begin
    t_s     = signed'(temp_i);
    h_s     = signed'(hi_i);
    l_s     = signed'(lo_i);
    ge_hi_o = (t_s >= h_s);
    lt_lo_o = (t_s <  l_s);
  end
endmodule

// File: rtl/tac_fault_cnt.sv
// Counts consecutive qualifying results; flags the result that completes the run.
module tac_fault_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             qual_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_en;

  assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign hit_o   = en_i & qual_i & (cnt_inc == need_i);

  always_comb begin
    cnt_en = clr_i | en_i;
    cnt_d  = cnt_q;
    if (clr_i || hit_o || (en_i && !qual_i)) cnt_d = '0;
    else if (en_i && qual_i)                 cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tac_alert_fsm.sv
// Alert state and watched threshold, with the precedence of clears over counting.
module tac_alert_fsm
  import tac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample_vld,
  input  logic mode_intr,
  input  logic reg_rd,
  input  logic ara_ack,
  input  logic shdn,
  input  logic gen_rst,
  input  logic ge_hi,
  input  logic lt_lo,
  input  logic hit,
  output logic cnt_en,
  output logic cnt_clr,
  output logic qual,
  output logic alert_act
);
  logic   act_q, act_d;
  watch_e watch_q, watch_d;
  logic   ack_evt, accept;

  always_comb begin
    ack_evt = mode_intr & act_q & (reg_rd | ara_ack);
    accept  = sample_vld & ~shdn & ~gen_rst & ~ack_evt;
    cnt_en  = accept & ~(mode_intr & act_q);
    cnt_clr = gen_rst | shdn | ack_evt;
    if (mode_intr) qual = (watch_q == WATCH_LO) ? lt_lo : ge_hi;
    else           qual = act_q ? lt_lo : ge_hi;
  end

  always_comb begin
    act_d   = act_q;
    watch_d = watch_q;
    if (gen_rst) begin
      act_d   = 1'b0;
      watch_d = WATCH_HI;
    end else if (shdn || ack_evt) begin
      act_d = 1'b0;
      if (mode_intr && act_q) watch_d = watch_e'(~watch_q);
    end else if (hit) begin
      act_d = mode_intr ? 1'b1 : ~act_q;
    end
    if (!mode_intr && !gen_rst) watch_d = WATCH_HI;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      watch_q <= WATCH_HI;
    end else begin
      act_q   <= act_d;
      watch_q <= watch_d;
    end
  end

  assign alert_act = act_q;
endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl
  import tac_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter int CNT_W  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_vld,
  input  logic [TEMP_W-1:0] sample_temp,
  input  logic [TEMP_W-1:0] lim_hi,
  input  logic [TEMP_W-1:0] lim_lo,
  input  logic              mode_intr,
  input  logic [1:0]        fault_sel,
  input  logic              reg_rd,
  input  logic              ara_ack,
  input  logic              shdn,
  input  logic              gen_rst,
  input  logic              pol_hi,
  output logic              alert_o
);
  logic             rst_n_int;
  logic             ge_hi, lt_lo;
  logic             cnt_en, cnt_clr, qual, hit, alert_act;
  logic [CNT_W-1:0] need;

  assign need = CNT_W'(run_need(run_sel_e'(fault_sel)));

  tac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  tac_limit_cmp #(.TEMP_W(TEMP_W)) u_cmp (
    .temp_i(sample_temp), .hi_i(lim_hi), .lo_i(lim_lo),
    .ge_hi_o(ge_hi), .lt_lo_o(lt_lo)
  );

  tac_fault_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_int), .clr_i(cnt_clr), .en_i(cnt_en),
    .qual_i(qual), .need_i(need), .hit_o(hit)
  );

  tac_alert_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_int), .sample_vld(sample_vld),
    .mode_intr(mode_intr), .reg_rd(reg_rd), .ara_ack(ara_ack),
    .shdn(shdn), .gen_rst(gen_rst), .ge_hi(ge_hi), .lt_lo(lt_lo),
    .hit(hit), .cnt_en(cnt_en), .cnt_clr(cnt_clr), .qual(qual),
    .alert_act(alert_act)
  );

  assign alert_o = pol_hi ? alert_act : ~alert_act;
endmodule

// File: rtl/tac_alert_chk.sv
module tac_alert_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_vld,
  input logic mode_intr,
  input logic reg_rd,
  input logic ara_ack,
  input logic shdn,
  input logic gen_rst,
  input logic pol_hi,
  input logic alert_o
);
  logic active;
  assign active = (alert_o == pol_hi);

  a_r6_shdn_clears: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> !active);

  a_r7_greset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    gen_rst |=> !active);

  a_r4_event_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_intr && active && !reg_rd && !ara_ack && !shdn && !gen_rst) |=> active);

  a_r4_level_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_intr && active && !sample_vld && !shdn && !gen_rst) |=> active);

  a_r11_rise_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !sample_vld) |=> !active);
endmodule

bind temp_alert_ctrl tac_alert_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .mode_intr(mode_intr),
  .reg_rd(reg_rd), .ara_ack(ara_ack), .shdn(shdn), .gen_rst(gen_rst),
  .pol_hi(pol_hi), .alert_o(alert_o)
);

// File: tb/sim_temp_alert_ctrl.sv
`timescale 1ns/1ps
module sim_temp_alert_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_vld;
  logic [11:0] sample_temp, lim_hi, lim_lo;
  logic        mode_intr;
  logic [1:0]  fault_sel;
  logic        reg_rd, ara_ack, shdn, gen_rst, pol_hi;
  logic        alert_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  temp_alert_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample_temp(sample_temp),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .mode_intr(mode_intr), .fault_sel(fault_sel),
    .reg_rd(reg_rd), .ara_ack(ara_ack), .shdn(shdn), .gen_rst(gen_rst),
    .pol_hi(pol_hi), .alert_o(alert_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        vld;
    logic [11:0] t;
    logic        md;
    logic [1:0]  f;
    logic        rd;
    logic        ack;
    logic        sd;
    logic        exp;
  } vec_t;

  localparam int NV = 37;
  // Threshold pair 0x500 / 0x4B0, active-high pin. exp is the pin after the edge.
  localparam vec_t TAB [NV] = '{
    '{4'd1 , 1'b1, 12'h500, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 equal counts
    '{4'd2 , 1'b1, 12'h4B0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 equal to low: no
    '{4'd8 , 1'b1, 12'h4AF, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 lsb below low
    '{4'd3 , 1'b1, 12'h600, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 run 1 of 2
    '{4'd3 , 1'b1, 12'h100, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 run broken
    '{4'd3 , 1'b1, 12'h600, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 run 1 of 2
    '{4'd3 , 1'b0, 12'h000, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 gap keeps run
    '{4'd3 , 1'b1, 12'h600, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 run 2 of 2
    '{4'd2 , 1'b1, 12'h4AF, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 run 1 of 2
    '{4'd4 , 1'b0, 12'h000, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1}, // R4 level ack ignored
    '{4'd2 , 1'b1, 12'h4AF, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 run 2 of 2
    '{4'd8 , 1'b1, 12'hF00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 negative
    '{4'd4 , 1'b1, 12'h7FF, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 event raise
    '{4'd4 , 1'b1, 12'h000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 held
    '{4'd4 , 1'b0, 12'h000, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 read clears
    '{4'd5 , 1'b1, 12'h700, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 high ignored
    '{4'd5 , 1'b1, 12'h4AF, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 low event
    '{4'd5 , 1'b0, 12'h000, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 ack clears
    '{4'd5 , 1'b1, 12'h000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 low ignored
    '{4'd5 , 1'b1, 12'h500, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 high again
    '{4'd10, 1'b1, 12'h600, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0}, // R10 ack wins
    '{4'd10, 1'b1, 12'h400, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0}, // R10 run 1 of 2
    '{4'd10, 1'b1, 12'h400, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 run 2 of 2
    '{4'd6 , 1'b0, 12'h000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 shutdown clears
    '{4'd6 , 1'b1, 12'h700, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 sample ignored
    '{4'd6 , 1'b1, 12'h700, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 watch swapped
    '{4'd4 , 1'b0, 12'h000, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 clear
    '{4'd3 , 1'b1, 12'h500, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 six: 1
    '{4'd3 , 1'b1, 12'h500, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 six: 2
    '{4'd3 , 1'b1, 12'h500, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 six: 3
    '{4'd3 , 1'b1, 12'h500, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 six: 4
    '{4'd3 , 1'b1, 12'h500, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 six: 5
    '{4'd3 , 1'b1, 12'h500, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 six: 6
    '{4'd3 , 1'b1, 12'h100, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 four: 1
    '{4'd3 , 1'b1, 12'h100, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 four: 2
    '{4'd3 , 1'b1, 12'h100, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 four: 3
    '{4'd3 , 1'b1, 12'h100, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0}  // R3 four: 4
  };

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (alert_o !== exp) begin
      n_bad++;
      $display("FAIL %s: alert_o=%b expected %b at %0t", tag, alert_o, exp, $time);
    end
  endtask

  task automatic step(input logic vld, input logic [11:0] t, input logic md,
                      input logic [1:0] f, input logic rd, input logic ack,
                      input logic sd, input logic gr);
    @(negedge clk);
    sample_vld = vld; sample_temp = t; mode_intr = md; fault_sel = f;
    reg_rd = rd; ara_ack = ack; shdn = sd; gen_rst = gr;
    @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; sample_vld = 1'b0; sample_temp = '0; lim_hi = 12'h500;
    lim_lo = 12'h4B0; mode_intr = 1'b0; fault_sel = 2'b00; reg_rd = 1'b0;
    ara_ack = 1'b0; shdn = 1'b0; gen_rst = 1'b0; pol_hi = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(1'b1, "R9 reset inactive, active-low");
    pol_hi = 1'b1; #1;
    check(1'b0, "R9 reset inactive, active-high");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      step(TAB[i].vld, TAB[i].t, TAB[i].md, TAB[i].f, TAB[i].rd, TAB[i].ack, TAB[i].sd, 1'b0);
      check(TAB[i].exp, $sformatf("R%0d vector %0d", TAB[i].req, i));
    end

    // R9: polarity applies immediately to an active alert
    step(1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 12'h600, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    check(1'b1, "R9 active-high level");
    pol_hi = 1'b0; #1;
    check(1'b0, "R9 active-low level");
    pol_hi = 1'b1; #1;

    // R7: general reset clears an active alert
    step(1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
    check(1'b0, "R7 alert cleared");

    // R7: general reset restores watching the upper threshold
    step(1'b1, 12'h600, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 12'h000, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 12'h000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 12'h700, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    check(1'b1, "R7 watch back to upper");
    step(1'b0, 12'h000, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);

    // R7: general reset clears a partial run
    step(1'b0, 12'h000, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 12'h600, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 12'h000, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 12'h600, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    check(1'b0, "R7 run count cleared");
    step(1'b1, 12'h600, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    check(1'b1, "R7 run completes after restart");

    // R11: output changes only after the strobing edge
    step(1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    sample_vld = 1'b1; sample_temp = 12'h600; gen_rst = 1'b0; #1;
    check(1'b0, "R11 before edge");
    @(posedge clk); #1;
    check(1'b1, "R11 after edge");

    // R8: negative upper threshold, signed compare
    step(1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
    lim_hi = 12'hF80; lim_lo = 12'hF00;
    step(1'b1, 12'hF7F, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    check(1'b0, "R8 below negative threshold");
    step(1'b1, 12'hF80, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    check(1'b1, "R8 equal negative threshold");

    step(1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    summary();
  end
endmodule